// File: doc/BRIEF.md
# Serial link request transmitter

This block turns parallel link-layer service requests into a framed serial bit stream on a single request wire. The wire is sampled once per clock by the receiving side. A command is offered on a valid/ready interface. Its 3-bit type code selects one of four frame shapes:

- a bus request, which carries a 3-bit speed code;
- a register read, which carries a 4-bit address;
- a register write, which carries a 4-bit address and 8 data bits;
- an arbitration-acceleration control, which carries one enable bit.

Each frame opens with a 1 and normally closes with a 0. The bits leave one per clock, frame bit 0 first. The wire stays low when no frame is being sent.

One frame shape has an irregular length. When the last speed bit of a bus request is 0, the closing 0 is left off, because the line returning low already ends the frame. This makes bus frames 7 or 8 bits long. The reserved type code is refused: it causes a one-cycle error pulse and nothing is sent.

Top module: `lreq_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_line` and `req_err` are 0 and `cmd_ready` is 1.
- R2: A command is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the cycle after the acceptance edge, `req_line` carries frame bit 0, which is always 1. Frame bit k appears k cycles later.
- R3: Frame bits 1 to 3 carry `cmd_type`, most significant bit first. Codes 0 to 3 are bus requests (immediate, isochronous, priority, fair), 4 is a register read, 5 is a register write, 6 is acceleration control and 7 is reserved.
- R4: A bus request carries `cmd_speed` in frame bits 4 to 6, most significant bit first. When `cmd_speed[0]` is 1, frame bit 7 is a 0 stop bit and the frame is 8 bits long.
- R5: A bus request with `cmd_speed[0]` equal to 0 is 7 bits long and has no stop bit.
- R6: A register read is 9 bits long: `cmd_addr` (MSB first) in frame bits 4 to 7, then a 0 stop bit.
- R7: A register write is 17 bits long: `cmd_addr` in frame bits 4 to 7, `cmd_data` in frame bits 8 to 15 (each field MSB first), then a 0 stop bit.
- R8: An acceleration control is 6 bits long: `cmd_accel_en` in frame bit 4, then a 0 stop bit.
- R9: `cmd_ready` is 0 for every cycle of a frame and for one further cycle after it, then returns to 1. A `cmd_valid` offered while `cmd_ready` is 0 is ignored and does not change the wire.
- R10: In every cycle that carries no frame bit, `req_line` is 0.
- R11: Accepting type code 7 sends nothing. It makes `req_err` 1 for exactly the following cycle, and `cmd_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the wire changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_type | input | 3 | Request type code, as listed in R3 |
| cmd_speed | input | SPEED_W (3) | Speed code for bus requests |
| cmd_addr | input | ADDR_W (4) | Register address for read and write |
| cmd_data | input | DATA_W (8) | Write data |
| cmd_accel_en | input | 1 | Enable bit for acceleration control |
| req_line | output | 1 | Serial request wire |
| req_err | output | 1 | One-cycle pulse when a reserved code is accepted |

## Verification
Bus requests cover all four bus codes. They are sent with speed codes whose last bit is 1 and with speed codes whose last bit is 0, which separates the 8-bit frame from the shortened 7-bit frame. Reads and writes use non-symmetric addresses and data, so swapped fields or a wrong bit order become visible. Acceleration control is sent with the enable bit both set and clear. A reserved code followed at once by a valid read shows that the rejection leaves the block ready. Commands held valid during a busy frame, and long idle stretches, confirm that the wire only moves for accepted frames.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

   localparam int unsigned CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      K_IMMED  = 3'd0,
      K_ISOCH  = 3'd1,
      K_PRIO   = 3'd2,
      K_FAIR   = 3'd3,
      K_REG_RD = 3'd4,
      K_REG_WR = 3'd5,
      K_ACCEL  = 3'd6,
      K_RSVD   = 3'd7
   } req_code_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lreq_frame_build.sv
module lreq_frame_build
   import lreq_pkg::*;
#(
   parameter int unsigned SPEED_W       = 3,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 8,
   parameter bit          TRIM_BUS_STOP = 1'b1,
   parameter int unsigned FRAME_W       = 17,
   parameter int unsigned LEN_W         = 5
) (
   input  req_code_e            code,
   input  logic [SPEED_W-1:0]   speed,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    data,
   input  logic                 accel_en,
   output logic [FRAME_W-1:0]   frame,
   output logic [LEN_W-1:0]     len
);

   localparam int unsigned HDR_W = 1 + CODE_W;
   localparam int unsigned BUS_W = HDR_W + SPEED_W + 1;
   localparam int unsigned RD_W  = HDR_W + ADDR_W + 1;
   localparam int unsigned WR_W  = HDR_W + ADDR_W + DATA_W + 1;
   localparam int unsigned ACC_W = HDR_W + 2;

   initial begin
      assert (FRAME_W >= imax(imax(BUS_W, RD_W), imax(WR_W, ACC_W)))
         else $error("frame register too narrow");
      assert ((1 << LEN_W) > FRAME_W + 1)
         else $error("length counter too narrow");
   end

   logic [LEN_W-1:0] bus_len;

   generate
      if (TRIM_BUS_STOP) begin : g_trim
         assign bus_len = speed[0] ? LEN_W'(BUS_W) : LEN_W'(BUS_W - 1);
      end else begin : g_keep
         assign bus_len = LEN_W'(BUS_W);
      end
   endgenerate

   always_comb begin
      frame = '0;
      len   = '0;
      unique case (code)
         K_REG_RD: begin
            frame = FRAME_W'({1'b1, code, addr, 1'b0}) << (FRAME_W - RD_W);
            len   = LEN_W'(RD_W);
         end
         K_REG_WR: begin
            frame = FRAME_W'({1'b1, code, addr, data, 1'b0}) << (FRAME_W - WR_W);
            len   = LEN_W'(WR_W);
         end
         K_ACCEL: begin
            frame = FRAME_W'({1'b1, code, accel_en, 1'b0}) << (FRAME_W - ACC_W);
            len   = LEN_W'(ACC_W);
         end
         K_RSVD: begin
            frame = '0;
            len   = '0;
         end
         default: begin
            frame = FRAME_W'({1'b1, code, speed, 1'b0}) << (FRAME_W - BUS_W);
            len   = bus_len;
         end
      endcase
   end

endmodule

// File: rtl/lreq_shift.sv
module lreq_shift #(
   parameter int unsigned FRAME_W = 17,
   parameter int unsigned LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [LEN_W-1:0]   len,
   output logic               ser_out,
   output logic               idle
);

   logic [FRAME_W-1:0] sr;
   logic [LEN_W-1:0]   rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr  <= '0;
         rem <= '0;
      end else if (load) begin
         sr  <= frame;
         rem <= len + LEN_W'(1);
      end else begin
         sr  <= sr << 1;
         if (rem != '0) rem <= rem - LEN_W'(1);
      end
   end

   assign ser_out = sr[FRAME_W-1];
   assign idle    = (rem == '0);

   p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !idle);
   p_gap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rem == LEN_W'(1)) |-> !ser_out);
   p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !ser_out);

endmodule

// File: rtl/lreq_tx.sv
module lreq_tx
   import lreq_pkg::*;
#(
   parameter int unsigned SPEED_W       = 3,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 8,
   parameter bit          TRIM_BUS_STOP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [CODE_W-1:0]  cmd_type,
   input  logic [SPEED_W-1:0] cmd_speed,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [DATA_W-1:0]  cmd_data,
   input  logic               cmd_accel_en,
   output logic               req_line,
   output logic               req_err
);

   localparam int unsigned HDR_W   = 1 + CODE_W;
   localparam int unsigned BUS_W   = HDR_W + SPEED_W + 1;
   localparam int unsigned RD_W    = HDR_W + ADDR_W + 1;
   localparam int unsigned WR_W    = HDR_W + ADDR_W + DATA_W + 1;
   localparam int unsigned ACC_W   = HDR_W + 2;
   localparam int unsigned FRAME_W = imax(imax(BUS_W, RD_W), imax(WR_W, ACC_W));
   localparam int unsigned LEN_W   = $clog2(FRAME_W + 2);

   initial begin
      assert (SPEED_W >= 1 && ADDR_W >= 1 && DATA_W >= 1)
         else $error("field widths must be at least one bit");
   end

   req_code_e          code;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   len;
   logic               accept;
   logic               reserved;
   logic               load;
   logic               idle;

   assign code     = req_code_e'(cmd_type);
   assign accept   = cmd_valid && cmd_ready;
   assign reserved = (code == K_RSVD);
   assign load     = accept && !reserved;

   lreq_frame_build #(
      .SPEED_W       (SPEED_W),
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .TRIM_BUS_STOP (TRIM_BUS_STOP),
      .FRAME_W       (FRAME_W),
      .LEN_W         (LEN_W)
   ) u_build (
      .code     (code),
      .speed    (cmd_speed),
      .addr     (cmd_addr),
      .data     (cmd_data),
      .accel_en (cmd_accel_en),
      .frame    (frame),
      .len      (len)
   );

   lreq_shift #(
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .frame   (frame),
      .len     (len),
      .ser_out (req_line),
      .idle    (idle)
   );

   assign cmd_ready = idle;

   always_ff @(posedge clk) begin
      if (!rst_n) req_err <= 1'b0;
      else        req_err <= accept && reserved;
   end

   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> req_line);
   p_rsvd_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && reserved) |=> (req_err && cmd_ready && !req_line));
   p_err_only_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $past(cmd_valid && cmd_type == K_RSVD));

endmodule

// File: tb/lreq_tx_bench.sv
module lreq_tx_bench;

   typedef bit bitq_t[$];

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [2:0] cmd_type = 3'd0;
   logic [2:0] cmd_speed = 3'd0;
   logic [3:0] cmd_addr = 4'd0;
   logic [7:0] cmd_data = 8'd0;
   logic       cmd_accel_en = 1'b0;
   logic       req_line;
   logic       req_err;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_tag = "R1";

   bitq_t exp_q;
   bit    exp_out = 1'b0;
   bit    exp_err = 1'b0;
   int    exp_rem = 0;

   always #2.5 clk = ~clk;

   lreq_tx u_lreq_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_type     (cmd_type),
      .cmd_speed    (cmd_speed),
      .cmd_addr     (cmd_addr),
      .cmd_data     (cmd_data),
      .cmd_accel_en (cmd_accel_en),
      .req_line     (req_line),
      .req_err      (req_err)
   );

   function automatic bitq_t make_frame(input int t, input logic [2:0] sp,
                                        input logic [3:0] ad, input logic [7:0] d,
                                        input logic en);
      bitq_t b = {};
      b.push_back(1'b1);
      for (int i = 2; i >= 0; i--) b.push_back(t[i]);
      if (t < 4) begin
         for (int i = 2; i >= 0; i--) b.push_back(sp[i]);
         if (sp[0]) b.push_back(1'b0);
      end else if (t == 4) begin
         for (int i = 3; i >= 0; i--) b.push_back(ad[i]);
         b.push_back(1'b0);
      end else if (t == 5) begin
         for (int i = 3; i >= 0; i--) b.push_back(ad[i]);
         for (int i = 7; i >= 0; i--) b.push_back(d[i]);
         b.push_back(1'b0);
      end else begin
         b.push_back(en);
         b.push_back(1'b0);
      end
      return b;
   endfunction

   // reference model: advances on each rising edge from the sampled inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
         exp_out = 1'b0;
         exp_err = 1'b0;
         exp_rem = 0;
      end else begin
         bit acc;
         acc     = cmd_valid && (exp_rem == 0);
         exp_err = acc && (cmd_type == 3'd7);
         if (acc && cmd_type != 3'd7) begin
            exp_q   = make_frame(int'(cmd_type), cmd_speed, cmd_addr, cmd_data, cmd_accel_en);
            exp_rem = exp_q.size() + 1;
         end else if (exp_rem > 0) begin
            exp_rem = exp_rem - 1;
         end
         exp_out = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
      end
   end

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_tag, "req_line", req_line, exp_out);
         chk(cur_tag, "cmd_ready", cmd_ready, exp_rem == 0);
         chk(cur_tag, "req_err", req_err, exp_err);
      end
   end

   task automatic send(input string tag, input int t, input logic [2:0] sp,
                       input logic [3:0] ad, input logic [7:0] d, input logic en);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cur_tag      = tag;
      cmd_valid    = 1'b1;
      cmd_type     = 3'(t);
      cmd_speed    = sp;
      cmd_addr     = ad;
      cmd_data     = d;
      cmd_accel_en = en;
      @(negedge clk);
      cmd_valid    = 1'b0;
   endtask

   task automatic idle_cycles(input string tag, input int n);
      cur_tag = tag;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "req_line in reset", req_line, 1'b0);
      chk("R1", "cmd_ready in reset", cmd_ready, 1'b1);
      chk("R1", "req_err in reset", req_err, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_line after reset", req_line, 1'b0);
      chk("R1", "cmd_ready after reset", cmd_ready, 1'b1);

      // R2, R3, R4: bus requests with speed LSB 1 (8-bit frames)
      send("R2", 3, 3'b101, 4'h0, 8'h00, 1'b0);
      send("R4", 2, 3'b111, 4'h0, 8'h00, 1'b0);
      send("R3", 1, 3'b011, 4'h0, 8'h00, 1'b0);
      idle_cycles("R10", 10);

      // R5: speed LSB 0 gives 7-bit frames
      send("R5", 0, 3'b010, 4'h0, 8'h00, 1'b0);
      send("R5", 1, 3'b000, 4'h0, 8'h00, 1'b0);
      send("R5", 3, 3'b110, 4'h0, 8'h00, 1'b0);
      idle_cycles("R10", 10);

      // R6: register read
      send("R6", 4, 3'b000, 4'hA, 8'h00, 1'b0);
      send("R6", 4, 3'b000, 4'h3, 8'h00, 1'b0);

      // R7: register write
      send("R7", 5, 3'b000, 4'h5, 8'hC3, 1'b0);
      send("R7", 5, 3'b000, 4'hE, 8'h2B, 1'b0);

      // R8: acceleration control, enable set and clear
      send("R8", 6, 3'b000, 4'h0, 8'h00, 1'b1);
      send("R8", 6, 3'b000, 4'h0, 8'h00, 1'b0);

      // R11: reserved code rejected, then a read right after
      send("R11", 7, 3'b111, 4'hF, 8'hFF, 1'b1);
      send("R11", 4, 3'b000, 4'h9, 8'h00, 1'b0);

      // R9: valid offered while busy is ignored
      send("R9", 5, 3'b000, 4'h6, 8'h91, 1'b0);
      cmd_valid    = 1'b1;
      cmd_type     = 3'd6;
      cmd_accel_en = 1'b1;
      repeat (5) @(negedge clk);
      cmd_valid    = 1'b0;
      idle_cycles("R9", 20);

      // R9: valid held high across back-to-back commands
      cur_tag   = "R9";
      cmd_type  = 3'd0;
      cmd_speed = 3'b001;
      cmd_valid = 1'b1;
      repeat (25) @(negedge clk);
      cmd_valid = 1'b0;

      idle_cycles("R10", 30);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule